// File: doc/BRIEF.md
# Ultra-DMA Operation Control and Status Unit

This block holds the register-side controls for an Ultra-DMA transfer engine. A host writes the direction of the next burst and, through a fixed three-step sequence, the enable bit that hands the bus to the engine. The block refuses an enable request that arrives out of order. It also owns four bus control levels: both chip selects and both strobes, all active low. A single stop write clears the operation register and drives all four controls back to their idle high level.

On the status side, the block merges live flags from the engine (data request and busy) with sticky error flags (engine fault, data-out not completed, data-in not completed, transfer length not a multiple of four 32-bit words) into one readable word. Sticky flags clear by writing ones. A two-bit summary code, priority encoded, tells a higher-level sequencer at a glance whether the transfer has failed, the device is interrupting, the engine is working, or nothing is happening.

The host reaches four word registers: bus controls at address 0, operation at address 1, status at address 2 and stop at address 3. A read returns data combinationally in the cycle that `bus_rd` is high. Writes take effect at the next clock edge.

Top module: `udma_ctl_stat`

## Requirements
- R1: After reset `xfer_en` and `xfer_dir` are 0, `cs0_n`, `cs1_n`, `rd_stb_n` and `wr_stb_n` are 1, `summary` is 0 (idle) and the status word reads 0.
- R2: A write to address 1 with bit 0 clear sets `xfer_dir` to bit 1 of the data (1 = host to device) and clears `xfer_en`; a read of address 1 returns enable in bit 0 and direction in bit 1.
- R3: The enable bit is set only by the sequence: write to address 1 with bit 0 clear, then a read of address 1, then a write to address 1 with bit 0 set and the same direction bit.
- R4: A write to address 1 with bit 0 set that does not directly follow a read of address 1 in that sequence (no preceding direction write, or any other bus access in between) is ignored: `xfer_en` stays 0 and `xfer_dir` is unchanged.
- R5: An enable write whose direction bit differs from the direction just written is ignored; `xfer_en` stays 0.
- R6: Status bit 16 follows `eng_dreq` and status bit 18 follows `eng_busy`.
- R7: A one-cycle pulse on `eng_fault`, `eng_nd_out`, `eng_nd_in` or `eng_short` sets status bit 17, 24, 25 or 26 respectively; the bit stays set until a write to address 2 with a 1 in that bit position, which clears only the bits written as 1.
- R8: `summary` is 3 (error) when any of status bits 17, 24, 25, 26 is set; else 2 (interrupt) when `dev_intrq` is high; else 1 (active) when status bit 18 or 16 is set; else 0 (idle).
- R9: A write to address 0 drives `cs0_n`, `cs1_n`, `rd_stb_n`, `wr_stb_n` from data bits 0, 1, 2, 3.
- R10: Any write to address 3 clears `xfer_en` and `xfer_dir`, forces all four bus controls to 1, and restarts the arming sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (2) | Word address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid while `bus_rd` is high |
| eng_dreq | input | 1 | Engine data request, live |
| eng_fault | input | 1 | Engine error interrupt pulse |
| eng_busy | input | 1 | Engine not idle, live |
| eng_nd_out | input | 1 | Data-out not completed pulse |
| eng_nd_in | input | 1 | Data-in not completed pulse |
| eng_short | input | 1 | Length not a multiple of four words pulse |
| dev_intrq | input | 1 | Device interrupt request line |
| xfer_en | output | 1 | Engine enable |
| xfer_dir | output | 1 | Direction, 1 = host to device |
| cs0_n | output | 1 | Chip select 0, active low |
| cs1_n | output | 1 | Chip select 1, active low |
| rd_stb_n | output | 1 | Read strobe, active low |
| wr_stb_n | output | 1 | Write strobe, active low |
| summary | output | 2 | 3 error, 2 interrupt, 1 active, 0 idle |

## Verification
The hardest situation to reach is an enable write that is almost legal: a direction write and an operation read did happen, but a status read slipped in between, or the direction bit changed at the last step. The stimulus builds each of these near-miss orders explicitly and then confirms that the legal order still arms afterwards. The summary priority is walked through a vector table in which sticky errors are planted by single-cycle pulses while the live request, busy and interrupt lines are held, so that every level of the priority is masked by the one above it at least once.

// File: rtl/udma_cs_pkg.sv
package udma_cs_pkg;
   localparam int REG_CTL    = 0;
   localparam int REG_OP     = 1;
   localparam int REG_STAT   = 2;
   localparam int REG_STOP   = 3;

   localparam int BIT_DREQ   = 16;
   localparam int BIT_FAULT  = 17;
   localparam int BIT_BUSY   = 18;
   localparam int BIT_NDOUT  = 24;
   localparam int BIT_NDIN   = 25;
   localparam int BIT_SHORT  = 26;
   localparam int STAT_MSB   = 26;

   localparam int NUM_ERR    = 4;

   typedef enum logic [1:0] {
      SUM_IDLE   = 2'd0,
      SUM_ACTIVE = 2'd1,
      SUM_INTR   = 2'd2,
      SUM_ERROR  = 2'd3
   } summary_e;

   typedef enum logic [1:0] {
      ARM_IDLE  = 2'd0,
      ARM_DIR   = 2'd1,
      ARM_READ  = 2'd2,
      ARM_RUN   = 2'd3
   } arm_state_e;
endpackage

// File: rtl/udma_arm_seq.sv
module udma_arm_seq
   import udma_cs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic op_wr,
   input  logic op_rd,
   input  logic other_acc,
   input  logic stop,
   input  logic wr_en_bit,
   input  logic wr_dir_bit,
   output logic en_q,
   output logic dir_q
);
   arm_state_e st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ARM_IDLE;
         en_q  <= 1'b0;
         dir_q <= 1'b0;
      end else if (stop) begin
         st_q  <= ARM_IDLE;
         en_q  <= 1'b0;
         dir_q <= 1'b0;
      end else if (op_wr) begin
         if (!wr_en_bit) begin
            st_q  <= ARM_DIR;
            en_q  <= 1'b0;
            dir_q <= wr_dir_bit;
         end else if (st_q == ARM_READ && wr_dir_bit == dir_q) begin
            st_q  <= ARM_RUN;
            en_q  <= 1'b1;
         end else if (st_q == ARM_READ) begin
            st_q  <= ARM_DIR;
         end
      end else if (op_rd) begin
         if (st_q == ARM_DIR) st_q <= ARM_READ;
      end else if (other_acc) begin
         if (st_q == ARM_READ) st_q <= ARM_DIR;
      end
   end

   // R3
   en_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> $past(st_q) == ARM_READ);

   // R4
   en_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_wr && wr_en_bit && !stop && st_q != ARM_READ) |=> $stable(en_q) && $stable(dir_q));

   // R10
   stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !en_q && !dir_q && st_q == ARM_IDLE);
endmodule

// File: rtl/udma_err_stat.sv
module udma_err_stat
   import udma_cs_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter bit STICKY_ERRORS = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eng_dreq,
   input  logic              eng_busy,
   input  logic [NUM_ERR-1:0] err_in,
   input  logic              dev_intrq,
   input  logic              clr_wr,
   input  logic [DATA_W-1:0] clr_data,
   output logic [DATA_W-1:0] stat_word,
   output summary_e          summary
);
   logic [NUM_ERR-1:0] flags;
   logic [NUM_ERR-1:0] clr_mask;

   assign clr_mask = clr_wr ? {clr_data[BIT_SHORT], clr_data[BIT_NDIN],
                               clr_data[BIT_NDOUT], clr_data[BIT_FAULT]}
                            : '0;

   generate
      if (STICKY_ERRORS) begin : g_sticky
         logic [NUM_ERR-1:0] flags_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags_q <= '0;
            else        flags_q <= (flags_q & ~clr_mask) | err_in;
         end
         assign flags = flags_q;

         // R7
         sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (($past(flags_q & ~clr_mask) & ~flags_q) == '0));

         // R7
         sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|err_in) |=> ((flags_q & $past(err_in)) == $past(err_in)));
      end else begin : g_live
         assign flags = err_in;
      end
   endgenerate

   always_comb begin
      stat_word            = '0;
      stat_word[BIT_DREQ]  = eng_dreq;
      stat_word[BIT_BUSY]  = eng_busy;
      stat_word[BIT_FAULT] = flags[0];
      stat_word[BIT_NDOUT] = flags[1];
      stat_word[BIT_NDIN]  = flags[2];
      stat_word[BIT_SHORT] = flags[3];
   end

   always_comb begin
      if (|flags)                  summary = SUM_ERROR;
      else if (dev_intrq)          summary = SUM_INTR;
      else if (eng_busy | eng_dreq) summary = SUM_ACTIVE;
      else                         summary = SUM_IDLE;
   end

   // R8
   summary_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_word[BIT_FAULT] | stat_word[BIT_NDOUT] | stat_word[BIT_NDIN] |
       stat_word[BIT_SHORT]) == (summary == SUM_ERROR));
endmodule

// File: rtl/udma_bus_ctl.sv
module udma_bus_ctl #(
   parameter int CTL_W = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_data,
   input  logic             stop,
   output logic [CTL_W-1:0] ctl_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '1;
      else if (stop)   ctl_q <= '1;
      else if (ctl_wr) ctl_q <= ctl_data;
   end

   // R10
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (&ctl_q));
endmodule

// File: rtl/udma_ctl_stat.sv
module udma_ctl_stat
   import udma_cs_pkg::*;
#(
   parameter int ADDR_W        = 2,
   parameter int DATA_W        = 32,
   parameter bit STICKY_ERRORS = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              eng_dreq,
   input  logic              eng_fault,
   input  logic              eng_busy,
   input  logic              eng_nd_out,
   input  logic              eng_nd_in,
   input  logic              eng_short,
   input  logic              dev_intrq,
   output logic              xfer_en,
   output logic              xfer_dir,
   output logic              cs0_n,
   output logic              cs1_n,
   output logic              rd_stb_n,
   output logic              wr_stb_n,
   output logic [1:0]        summary
);
   localparam int CTL_W = 4;

   generate
      if (DATA_W <= STAT_MSB) begin : g_bad_width
         $error("DATA_W must exceed the highest status bit");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must cover four registers");
      end
   endgenerate

   logic sel_ctl, sel_op, sel_stat, sel_stop;
   logic any_acc, stop;
   logic [CTL_W-1:0] ctl_q;
   logic [DATA_W-1:0] stat_word;
   summary_e sum_code;

   assign sel_ctl  = bus_addr == ADDR_W'(REG_CTL);
   assign sel_op   = bus_addr == ADDR_W'(REG_OP);
   assign sel_stat = bus_addr == ADDR_W'(REG_STAT);
   assign sel_stop = bus_addr == ADDR_W'(REG_STOP);
   assign any_acc  = bus_wr | bus_rd;
   assign stop     = bus_wr & sel_stop;

   udma_arm_seq i_arm (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_wr      (bus_wr & sel_op),
      .op_rd      (!bus_wr & bus_rd & sel_op),
      .other_acc  (any_acc & !sel_op),
      .stop       (stop),
      .wr_en_bit  (bus_wdata[0]),
      .wr_dir_bit (bus_wdata[1]),
      .en_q       (xfer_en),
      .dir_q      (xfer_dir)
   );

   udma_err_stat #(
      .DATA_W        (DATA_W),
      .STICKY_ERRORS (STICKY_ERRORS)
   ) i_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .eng_dreq  (eng_dreq),
      .eng_busy  (eng_busy),
      .err_in    ({eng_short, eng_nd_in, eng_nd_out, eng_fault}),
      .dev_intrq (dev_intrq),
      .clr_wr    (bus_wr & sel_stat),
      .clr_data  (bus_wdata),
      .stat_word (stat_word),
      .summary   (sum_code)
   );

   udma_bus_ctl #(.CTL_W(CTL_W)) i_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_wr   (bus_wr & sel_ctl),
      .ctl_data (bus_wdata[CTL_W-1:0]),
      .stop     (stop),
      .ctl_q    (ctl_q)
   );

   assign cs0_n    = ctl_q[0];
   assign cs1_n    = ctl_q[1];
   assign rd_stb_n = ctl_q[2];
   assign wr_stb_n = ctl_q[3];
   assign summary  = sum_code;

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_ctl)       bus_rdata[CTL_W-1:0] = ctl_q;
         else if (sel_op)   bus_rdata[1:0] = {xfer_dir, xfer_en};
         else if (sel_stat) bus_rdata = stat_word;
      end
   end

   // R2
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_op && !bus_wdata[0]) |=> !xfer_en && xfer_dir == $past(bus_wdata[1]));

   // R9
   ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_ctl) |=> ctl_q == $past(bus_wdata[CTL_W-1:0]));
endmodule

// File: tb/test_udma_ctl_stat.sv
module test_udma_ctl_stat;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic eng_dreq = 0, eng_fault = 0, eng_busy = 0, eng_nd_out = 0;
   logic eng_nd_in = 0, eng_short = 0, dev_intrq = 0;
   logic xfer_en, xfer_dir, cs0_n, cs1_n, rd_stb_n, wr_stb_n;
   logic [1:0] summary;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   udma_ctl_stat i_udma_ctl_stat (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_dreq(eng_dreq), .eng_fault(eng_fault), .eng_busy(eng_busy),
      .eng_nd_out(eng_nd_out), .eng_nd_in(eng_nd_in), .eng_short(eng_short),
      .dev_intrq(dev_intrq), .xfer_en(xfer_en), .xfer_dir(xfer_dir),
      .cs0_n(cs0_n), .cs1_n(cs1_n), .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n),
      .summary(summary)
   );

   // entry: [11:8] error pulses {short,nd_in,nd_out,fault}, [7] intrq,
   // [6] busy, [5] dreq, [1:0] expected summary
   localparam logic [11:0] VEC [11] = '{
      12'b0000_000_000_00,
      12'b0000_001_000_01,
      12'b0000_010_000_01,
      12'b0000_011_000_01,
      12'b0000_100_000_10,
      12'b0000_111_000_10,
      12'b0001_000_000_11,
      12'b0010_111_000_11,
      12'b0100_010_000_11,
      12'b1000_100_000_11,
      12'b1111_111_000_11
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   function automatic logic [31:0] exp_stat(input logic [3:0] m, input logic busy, input logic req);
      logic [31:0] s = '0;
      s[16] = req; s[18] = busy;
      s[17] = m[0]; s[24] = m[1]; s[25] = m[2]; s[26] = m[3];
      return s;
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 en", {31'd0, xfer_en}, 0);
      check("R1 dir", {31'd0, xfer_dir}, 0);
      check("R1 ctl", {28'd0, wr_stb_n, rd_stb_n, cs1_n, cs0_n}, 32'hF);
      check("R1 summary", {30'd0, summary}, 0);
      rd(2, d); check("R1 status", d, 0);

      // R8 R6 R7 priority table
      foreach (VEC[i]) begin
         wr(2, 32'hFFFF_FFFF);
         {eng_short, eng_nd_in, eng_nd_out, eng_fault} = VEC[i][11:8];
         {dev_intrq, eng_busy, eng_dreq} = VEC[i][7:5];
         @(negedge clk);
         {eng_short, eng_nd_in, eng_nd_out, eng_fault} = 4'b0;
         check("R8 summary", {30'd0, summary}, {30'd0, VEC[i][1:0]});
         rd(2, d);
         check("R6/R7 status", d, exp_stat(VEC[i][11:8], VEC[i][6], VEC[i][5]));
         {dev_intrq, eng_busy, eng_dreq} = 3'b0;
      end

      // R7 write-one-to-clear touches only written bits
      wr(2, 32'hFFFF_FFFF);
      eng_nd_out = 1; eng_short = 1;
      @(negedge clk);
      eng_nd_out = 0; eng_short = 0;
      repeat (2) @(negedge clk);
      rd(2, d); check("R7 sticky hold", d, exp_stat(4'b1010, 0, 0));
      wr(2, 32'h0100_0000);
      rd(2, d); check("R7 partial clear", d, exp_stat(4'b1000, 0, 0));
      check("R8 still error", {30'd0, summary}, 3);
      wr(2, 32'h0400_0000);
      check("R7 cleared summary", {30'd0, summary}, 0);

      // R2 direction write
      wr(1, 32'h2);
      check("R2 dir", {31'd0, xfer_dir}, 1);
      check("R2 en", {31'd0, xfer_en}, 0);

      // R3 legal arming
      rd(1, d); check("R2 op readback", d, 32'h2);
      wr(1, 32'h3);
      check("R3 armed en", {31'd0, xfer_en}, 1);
      check("R3 armed dir", {31'd0, xfer_dir}, 1);
      rd(1, d); check("R2 armed readback", d, 32'h3);

      // R10 stop
      wr(0, 32'h0);
      check("R9 ctl low", {28'd0, wr_stb_n, rd_stb_n, cs1_n, cs0_n}, 0);
      wr(0, 32'h5);
      check("R9 ctl pattern", {28'd0, wr_stb_n, rd_stb_n, cs1_n, cs0_n}, 32'h5);
      wr(3, 32'h0);
      check("R10 en", {31'd0, xfer_en}, 0);
      check("R10 dir", {31'd0, xfer_dir}, 0);
      check("R10 ctl", {28'd0, wr_stb_n, rd_stb_n, cs1_n, cs0_n}, 32'hF);

      // R10 sequence restarts: read then enable without direction write
      rd(1, d);
      wr(1, 32'h1);
      check("R10 no carry-over", {31'd0, xfer_en}, 0);

      // R4 enable write without read
      wr(1, 32'h2);
      wr(1, 32'h3);
      check("R4 no read en", {31'd0, xfer_en}, 0);
      check("R4 no read dir", {31'd0, xfer_dir}, 1);

      // R4 other access between read and enable
      wr(1, 32'h0);
      rd(1, d);
      rd(2, d);
      wr(1, 32'h1);
      check("R4 interleaved en", {31'd0, xfer_en}, 0);

      // R5 direction mismatch
      wr(1, 32'h0);
      rd(1, d);
      wr(1, 32'h3);
      check("R5 mismatch en", {31'd0, xfer_en}, 0);
      check("R5 mismatch dir", {31'd0, xfer_dir}, 0);

      // R3 legal order still works, direction 0
      wr(1, 32'h0);
      rd(1, d);
      wr(1, 32'h1);
      check("R3 armed dir0", {30'd0, xfer_dir, xfer_en}, 32'h1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule